// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block regulates the winding current of one H-bridge. It has two legs, A and B, and each leg has a high-side and a low-side gate. In the on phase the block drives the diagonal pair that matches the commanded polarity. When the external current comparator reports that the trip level has been reached, the block starts an off period of fixed length. During the off period the current decays through the bridge, either in slow decay or in mixed decay. Mixed decay is a fast-decay part, where the bridge is reversed, followed by a slow-decay part. When the off period ends, the next on phase starts.

Three inputs decide the decay style for each off period: a two-bit timing-mode input, a full-step flag and the decay request from the translator. The timing mode also selects the off length. It is either a fixed build-time count or a per-use count given on an input. After every gate change the comparator is ignored for a blanking window, so switching transients cannot end an on phase early. A dead-time stage in each leg keeps the two FETs of that leg from conducting together. While a FET is recirculating current, it is released as soon as the load current is reported near zero.

Top module: `chop_bridge`

## Requirements
- R1: Gate encoding is {b_lo, b_hi, a_lo, a_hi}. When enabled and not tripped, polarity 0 drives a_hi and b_lo (4'b1001) and polarity 1 drives b_hi and a_lo (4'b0110).
- R2: The trip flag is ignored while the blanking counter runs. Any gate change reloads the counter with BLANK_CYC. The flag is also ignored until the gates match the on pattern. With trip held high, each on pattern lasts exactly BLANK_CYC+3 cycles. A trip pulse that ends inside the window leaves the on pattern untouched.
- R3: Once blanking has expired, a trip raised between edges leaves the gates in the on pattern after the first edge. The gates leave the on pattern after the second edge.
- R4: Timing mode 2'b00 takes the off length from off_cycles, with 0 treated as 1. Every other mode uses FIXED_OFF_CYC. The length is captured when the trip is accepted. The on phase resumes after exactly that many cycles in the off state.
- R5: Slow decay releases the active high side and recirculates through both low sides (4'b1010). With off length L and dead time D, the pattern is observed for L-D cycles, or L-F-D cycles after a fast part of F cycles.
- R6: Mixed decay first drives the reversed pair for F = (L*5)>>4 cycles, then switches to slow decay. Polarity 0 reverses to 4'b0110 and polarity 1 to 4'b1001. The reversed pattern is visible for F-D cycles.
- R7: Mode 2'b00 gives mixed decay exactly when the decay request is high, in every step mode. Mode 2'b10 gives mixed decay unless full step is set. Modes 2'b01 and 2'b11 give mixed decay only when the request is high and full step is clear.
- R8: While the near-zero flag is high during an off period, no recirculating FET is on. The fast part drives no gate. The slow part keeps only the sink of the active pair: b_lo for polarity 0, a_lo for polarity 1.
- R9: The high and low gates of a leg are never on together. A gate turns on only after its partner has been off for at least DEAD_CYC cycles.
- R10: One edge after enable falls, all four gates are low, and the off and blanking timers are cleared. One edge after enable rises, the chopper is back in the on phase, and the gates show the on pattern after the second edge. No earlier off period is resumed.
- R11: During reset all gates are low. If enable is high at release, the on pattern appears after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Bridge enable; low forces all gates off |
| trip | input | 1 | Current comparator reached trip level |
| near_zero | input | 1 | Load current close to zero |
| polarity | input | 1 | Commanded current direction |
| decay_req | input | 1 | Translator asks for mixed decay (falling current) |
| full_step | input | 1 | Translator is in full-step mode |
| timing_mode | input | 2 | 00 count input, 01 fixed/auto, 10 fixed/forced mixed, 11 as 01 |
| off_cycles | input | OFF_W | Off length in cycles for timing mode 00 |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |

## Verification
A table of settings drives one off period per row. The rows cover each timing mode, full step on and off, both decay requests, both polarities and several off counts. For each row the cycles spent in the reversed pattern and in the both-low pattern are counted, which separates the decay policy, the 5/16 split and the off length. Directed runs hold trip high to measure the blanking-limited on time and pulse trip inside the window to show that it is ignored. They also raise the near-zero flag to show that recirculation stops, and drop enable in the middle of an off period to show that the timers restart. A monitor on every sample flags any leg overlap or any turn-on that comes sooner than the dead time.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Gate vector bit positions: {b_lo, b_hi, a_lo, a_hi}
    localparam int G_AH = 0;
    localparam int G_AL = 1;
    localparam int G_BH = 2;
    localparam int G_BL = 3;
    localparam int GATE_N = 4;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_ON   = 2'd1,
        CH_OFF  = 2'd2
    } chop_st_e;

    typedef enum logic [1:0] {
        TM_COUNT     = 2'b00,
        TM_AUTO      = 2'b01,
        TM_FORCE_MIX = 2'b10,
        TM_SPARE     = 2'b11
    } tmode_e;

    function automatic logic [GATE_N-1:0] gate_bit(input int idx);
        logic [GATE_N-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // Drive pair for the on phase.
    function automatic logic [GATE_N-1:0] on_gates(input logic pol);
        return pol ? (gate_bit(G_BH) | gate_bit(G_AL))
                   : (gate_bit(G_AH) | gate_bit(G_BL));
    endfunction

    // Reversed pair for the fast part of mixed decay.
    function automatic logic [GATE_N-1:0] fast_gates(input logic pol, input logic iz);
        if (iz) return '0;
        return pol ? (gate_bit(G_AH) | gate_bit(G_BL))
                   : (gate_bit(G_BH) | gate_bit(G_AL));
    endfunction

    // Low-side recirculation for slow decay.
    function automatic logic [GATE_N-1:0] slow_gates(input logic pol, input logic iz);
        if (iz) return pol ? gate_bit(G_AL) : gate_bit(G_BL);
        return gate_bit(G_AL) | gate_bit(G_BL);
    endfunction

endpackage

// File: rtl/chop_policy.sv
module chop_policy
    import chop_pkg::*;
#(
    parameter int OFF_W         = 16,
    parameter int FIXED_OFF_CYC = 1500
) (
    input  logic [1:0]       timing_mode,
    input  logic             full_step,
    input  logic             decay_req,
    input  logic [OFF_W-1:0] off_cycles,
    output logic             mixed_sel,
    output logic [OFF_W-1:0] off_len
);

    logic [OFF_W-1:0] raw_len;

    always_comb begin
        raw_len = (timing_mode == TM_COUNT) ? off_cycles : OFF_W'(FIXED_OFF_CYC);
        off_len = (raw_len == '0) ? OFF_W'(1) : raw_len;

        unique case (timing_mode)
            TM_COUNT:     mixed_sel = decay_req;
            TM_FORCE_MIX: mixed_sel = !full_step;
            default:      mixed_sel = decay_req && !full_step;
        endcase
    end

endmodule

// File: rtl/chop_leg.sv
module chop_leg #(
    parameter int DEAD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    output logic gate_hi,
    output logic gate_lo
);

    localparam int DW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam int DLOAD = (DEAD_CYC < 1) ? 0 : DEAD_CYC - 1;

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic [DW-1:0] cnt;
    } leg_t;

    leg_t r_q, r_d;
    logic drop;

    always_comb begin
        r_d  = r_q;
        drop = (r_q.hi && !want_hi) || (r_q.lo && !want_lo);
        r_d.hi = r_q.hi && want_hi;
        r_d.lo = r_q.lo && want_lo;
        if (drop) begin
            r_d.cnt = DW'(DLOAD);
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        if (!drop && r_q.cnt == '0) begin
            if (want_hi && !want_lo && !r_q.lo) begin
                r_d.hi = 1'b1;
            end else if (want_lo && !want_hi && !r_q.hi) begin
                r_d.lo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign gate_hi = r_q.hi;
    assign gate_lo = r_q.lo;

    // Checker state: cycles each side has been low, saturating at DEAD_CYC.
    logic [DW-1:0] hi_low_run, lo_low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_low_run <= DW'(DEAD_CYC);
            lo_low_run <= DW'(DEAD_CYC);
        end else begin
            hi_low_run <= r_q.hi ? '0 : ((int'(hi_low_run) >= DEAD_CYC) ? hi_low_run : hi_low_run + 1'b1);
            lo_low_run <= r_q.lo ? '0 : ((int'(lo_low_run) >= DEAD_CYC) ? lo_low_run : lo_low_run + 1'b1);
        end
    end

    // R9
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R9
    dead_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> (int'(lo_low_run) >= DEAD_CYC));

    // R9
    dead_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> (int'(hi_low_run) >= DEAD_CYC));

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int BLANK_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              trip,
    input  logic              near_zero,
    input  logic              polarity,
    input  logic              mixed_sel,
    input  logic [OFF_W-1:0]  off_len,
    input  logic [GATE_N-1:0] gates_q,
    output logic [GATE_N-1:0] intent
);

    localparam int BW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
    localparam int PW = OFF_W + 3;

    typedef struct packed {
        chop_st_e          st;
        logic [OFF_W-1:0]  cnt;
        logic [OFF_W-1:0]  len;
        logic [OFF_W-1:0]  flen;
        logic              mixed;
        logic [BW-1:0]     blank;
        logic [GATE_N-1:0] prev;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  evt, settled, fast_now, accept;
    logic [PW-1:0] prod;

    always_comb begin
        prod     = PW'(off_len) * PW'(5);
        fast_now = r_q.mixed && (r_q.cnt < r_q.flen);

        unique case (r_q.st)
            CH_ON:   intent = on_gates(polarity);
            CH_OFF:  intent = fast_now ? fast_gates(polarity, near_zero)
                                       : slow_gates(polarity, near_zero);
            default: intent = '0;
        endcase
        if (!en) intent = '0;

        evt     = (gates_q != r_q.prev);
        settled = (gates_q == intent);
        accept  = trip && !evt && (r_q.blank == '0) && settled;

        r_d      = r_q;
        r_d.prev = gates_q;
        if (evt)                  r_d.blank = BW'(BLANK_CYC);
        else if (r_q.blank != '0) r_d.blank = r_q.blank - 1'b1;

        if (!en) begin
            r_d.st    = CH_IDLE;
            r_d.cnt   = '0;
            r_d.blank = '0;
        end else begin
            unique case (r_q.st)
                CH_IDLE: r_d.st = CH_ON;
                CH_ON: begin
                    if (accept) begin
                        r_d.st    = CH_OFF;
                        r_d.cnt   = '0;
                        r_d.len   = off_len;
                        r_d.flen  = OFF_W'(prod >> 4);
                        r_d.mixed = mixed_sel;
                    end
                end
                CH_OFF: begin
                    if (r_q.cnt == r_q.len - 1'b1) begin
                        r_d.st  = CH_ON;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.st = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= CH_IDLE;
            r_q.len <= OFF_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    // R2
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CH_ON && r_q.blank != '0 && en) |=> (r_q.st == CH_ON));

    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CH_OFF && en && r_q.cnt != r_q.len - 1'b1) |=> (r_q.st == CH_OFF));

    // R4
    off_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CH_OFF && en && r_q.cnt == r_q.len - 1'b1) |=> (r_q.st == CH_ON));

endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
    import chop_pkg::*;
#(
    parameter int OFF_W         = 16,
    parameter int FIXED_OFF_CYC = 1500,
    parameter int BLANK_CYC     = 50,
    parameter int DEAD_CYC      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trip,
    input  logic             near_zero,
    input  logic             polarity,
    input  logic             decay_req,
    input  logic             full_step,
    input  logic [1:0]       timing_mode,
    input  logic [OFF_W-1:0] off_cycles,
    output logic             a_hi,
    output logic             a_lo,
    output logic             b_hi,
    output logic             b_lo
);

    localparam int LEG_N = GATE_N / 2;

    logic              mixed_sel;
    logic [OFF_W-1:0]  off_len;
    logic [GATE_N-1:0] intent;
    logic [GATE_N-1:0] gates_q;

    chop_policy #(
        .OFF_W        (OFF_W),
        .FIXED_OFF_CYC(FIXED_OFF_CYC)
    ) i_policy (
        .timing_mode(timing_mode),
        .full_step  (full_step),
        .decay_req  (decay_req),
        .off_cycles (off_cycles),
        .mixed_sel  (mixed_sel),
        .off_len    (off_len)
    );

    chop_ctrl #(
        .OFF_W    (OFF_W),
        .BLANK_CYC(BLANK_CYC)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .trip     (trip),
        .near_zero(near_zero),
        .polarity (polarity),
        .mixed_sel(mixed_sel),
        .off_len  (off_len),
        .gates_q  (gates_q),
        .intent   (intent)
    );

    for (genvar g = 0; g < LEG_N; g++) begin : g_leg
        chop_leg #(
            .DEAD_CYC(DEAD_CYC)
        ) i_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .want_hi(intent[2*g]),
            .want_lo(intent[2*g+1]),
            .gate_hi(gates_q[2*g]),
            .gate_lo(gates_q[2*g+1])
        );
    end

    assign a_hi = gates_q[G_AH];
    assign a_lo = gates_q[G_AL];
    assign b_hi = gates_q[G_BH];
    assign b_lo = gates_q[G_BL];

    // R10
    gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gates_q == '0));

endmodule

// File: tb/test_chop_bridge.sv
module test_chop_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 8;
    localparam int FIXED      = 32;
    localparam int BLANK      = 4;
    localparam int DEAD       = 2;
    localparam int NV         = 11;

    typedef struct packed {
        logic [1:0] tm;
        logic       fs;
        logic       dr;
        logic       pol;
        logic [7:0] offc;
        logic [7:0] efast;
        logic [7:0] eslow;
    } vec_t;

    // mode, full step, decay req, polarity, off count, fast samples, slow samples
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 1'b0, 8'd20, 8'd4,  8'd12},
        '{2'd0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd0,  8'd18},
        '{2'd0, 1'b1, 1'b1, 1'b0, 8'd48, 8'd13, 8'd31},
        '{2'd1, 1'b0, 1'b1, 1'b0, 8'd5,  8'd8,  8'd20},
        '{2'd1, 1'b1, 1'b1, 1'b0, 8'd5,  8'd0,  8'd30},
        '{2'd1, 1'b0, 1'b0, 1'b1, 8'd5,  8'd0,  8'd30},
        '{2'd2, 1'b0, 1'b0, 1'b0, 8'd5,  8'd8,  8'd20},
        '{2'd2, 1'b1, 1'b0, 1'b0, 8'd5,  8'd0,  8'd30},
        '{2'd2, 1'b0, 1'b1, 1'b1, 8'd5,  8'd8,  8'd20},
        '{2'd3, 1'b0, 1'b1, 1'b1, 8'd9,  8'd8,  8'd20},
        '{2'd0, 1'b0, 1'b1, 1'b1, 8'd33, 8'd8,  8'd21}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, trip = 1'b0, near_zero = 1'b0, pol = 1'b0;
    logic dreq = 1'b0, fstep = 1'b0;
    logic [1:0] tmode = 2'd1;
    logic [OFF_W-1:0] offc = 8'd20;
    logic a_hi, a_lo, b_hi, b_lo;
    logic [3:0] g;

    assign g = {b_lo, b_hi, a_lo, a_hi};

    always #(CLK_PERIOD/2) clk = ~clk;

    chop_bridge #(
        .OFF_W        (OFF_W),
        .FIXED_OFF_CYC(FIXED),
        .BLANK_CYC    (BLANK),
        .DEAD_CYC     (DEAD)
    ) i_chop_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .trip       (trip),
        .near_zero  (near_zero),
        .polarity   (pol),
        .decay_req  (dreq),
        .full_step  (fstep),
        .timing_mode(tmode),
        .off_cycles (offc),
        .a_hi       (a_hi),
        .a_lo       (a_lo),
        .b_hi       (b_hi),
        .b_lo       (b_lo)
    );

    int n_chk = 0;
    int n_fail = 0;
    int dt_viol = 0;
    int dt_rises = 0;

    // Patterns taken from R1, R5, R6
    function automatic logic [3:0] on_p(input logic p);
        return p ? 4'b0110 : 4'b1001;
    endfunction
    function automatic logic [3:0] fast_p(input logic p);
        return p ? 4'b1001 : 4'b0110;
    endfunction
    localparam logic [3:0] SLOW_P = 4'b1010;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_pat(input logic [3:0] p, input string tag);
        for (int k = 0; k < 400; k++) begin
            if (g == p) break;
            tick();
        end
        check(g == p, tag, int'(g), int'(p));
    endtask

    // R9 dead-time monitor on sampled gates
    logic pa_hi = 1'b0, pa_lo = 1'b0, pb_hi = 1'b0, pb_lo = 1'b0;
    int ra_hi = 99, ra_lo = 99, rb_hi = 99, rb_lo = 99;

    always @(negedge clk) begin
        if (rst_n) begin
            if (a_hi && a_lo) dt_viol++;
            if (b_hi && b_lo) dt_viol++;
            if (a_hi && !pa_hi) begin dt_rises++; if (ra_lo < DEAD) dt_viol++; end
            if (a_lo && !pa_lo) begin dt_rises++; if (ra_hi < DEAD) dt_viol++; end
            if (b_hi && !pb_hi) begin dt_rises++; if (rb_lo < DEAD) dt_viol++; end
            if (b_lo && !pb_lo) begin dt_rises++; if (rb_hi < DEAD) dt_viol++; end
        end
        ra_hi = a_hi ? 0 : ((ra_hi < 1000) ? ra_hi + 1 : ra_hi);
        ra_lo = a_lo ? 0 : ((ra_lo < 1000) ? ra_lo + 1 : ra_lo);
        rb_hi = b_hi ? 0 : ((rb_hi < 1000) ? rb_hi + 1 : rb_hi);
        rb_lo = b_lo ? 0 : ((rb_lo < 1000) ? rb_lo + 1 : rb_lo);
        pa_hi = a_hi; pa_lo = a_lo; pb_hi = b_hi; pb_lo = b_lo;
    end

    task automatic run_tests();
        int nf, ns, n_on, n_alo, n_bl, n_z;

        // R11 reset state and start-up
        tick(); en = 1'b1;
        repeat (5) tick();
        check(g == 4'b0000, "R11 gates low in reset", int'(g), 0);
        rst_n = 1'b1;
        tick();
        check(g == 4'b0000, "R11 one edge after release", int'(g), 0);
        tick();
        check(g == on_p(1'b0), "R11 on pattern after two edges", int'(g), int'(on_p(1'b0)));

        // Vector table: R1 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            tmode = VECS[i].tm; fstep = VECS[i].fs; dreq = VECS[i].dr;
            pol = VECS[i].pol; offc = VECS[i].offc; trip = 1'b0;
            wait_pat(on_p(pol), $sformatf("R1 on pattern row %0d", i));
            repeat (BLANK + 4) tick();
            check(g == on_p(pol), $sformatf("R1 on pattern held row %0d", i), int'(g), int'(on_p(pol)));
            trip = 1'b1;
            tick();
            check(g == on_p(pol), $sformatf("R3 still on after one edge row %0d", i), int'(g), int'(on_p(pol)));
            tick();
            check(g != on_p(pol), $sformatf("R3 left on after two edges row %0d", i), int'(g), -1);
            trip = 1'b0;
            nf = 0; ns = 0;
            for (int k = 0; k < 400; k++) begin
                if (g == on_p(pol)) break;
                if (g == fast_p(pol)) nf++;
                if (g == SLOW_P) ns++;
                tick();
            end
            check(nf == int'(VECS[i].efast), $sformatf("R6 R7 fast samples row %0d", i), nf, int'(VECS[i].efast));
            check(ns == int'(VECS[i].eslow), $sformatf("R4 R5 slow samples row %0d", i), ns, int'(VECS[i].eslow));
        end

        // R2 trip held high: on time bounded by blanking
        en = 1'b0; pol = 1'b0; tmode = 2'd1; dreq = 1'b0; fstep = 1'b0;
        repeat (10) tick();
        check(g == 4'b0000, "R10 gates low while disabled", int'(g), 0);
        trip = 1'b1; en = 1'b1;
        wait_pat(on_p(1'b0), "R2 first on");
        n_on = 0;
        for (int k = 0; k < 100; k++) begin
            if (g != on_p(1'b0)) break;
            n_on++;
            tick();
        end
        check(n_on == BLANK + 3, "R2 first on length with trip held", n_on, BLANK + 3);
        wait_pat(on_p(1'b0), "R2 second on");
        n_on = 0;
        for (int k = 0; k < 100; k++) begin
            if (g != on_p(1'b0)) break;
            n_on++;
            tick();
        end
        check(n_on == BLANK + 3, "R2 second on length with trip held", n_on, BLANK + 3);
        trip = 1'b0;

        // R2 short trip inside the blanking window is ignored
        en = 1'b0;
        repeat (10) tick();
        en = 1'b1;
        tick(); tick();
        check(g == on_p(1'b0), "R10 on two edges after enable", int'(g), int'(on_p(1'b0)));
        trip = 1'b1;
        tick(); tick();
        trip = 1'b0;
        n_on = 0;
        for (int k = 0; k < 20; k++) begin
            if (g == on_p(1'b0)) n_on++;
            tick();
        end
        check(n_on == 20, "R2 pulse in blanking ignored", n_on, 20);

        // R8 near-zero stops recirculation (forced mixed, fixed length)
        tmode = 2'd2; pol = 1'b0; near_zero = 1'b1;
        repeat (10) tick();
        trip = 1'b1;
        tick(); tick();
        trip = 1'b0;
        n_alo = 0; n_bl = 0; n_z = 0;
        for (int k = 0; k < 400; k++) begin
            if (g == on_p(1'b0)) break;
            if (a_lo) n_alo++;
            if (g == 4'b1000) n_bl++;
            if (g == 4'b0000) n_z++;
            tick();
        end
        check(n_alo == 0, "R8 no recirculating low side", n_alo, 0);
        check(n_z == 10, "R8 fast part drives nothing", n_z, 10);
        check(n_bl == 22, "R8 slow part keeps sink only", n_bl, 22);
        near_zero = 1'b0;

        // R10 enable drop in the middle of an off period
        tmode = 2'd1; dreq = 1'b0;
        repeat (10) tick();
        trip = 1'b1;
        tick(); tick();
        trip = 1'b0;
        repeat (5) tick();
        check(g != on_p(1'b0), "R10 inside off period", int'(g), -1);
        en = 1'b0;
        tick();
        check(g == 4'b0000, "R10 gates low one edge after disable", int'(g), 0);
        repeat (10) tick();
        check(g == 4'b0000, "R10 gates stay low", int'(g), 0);
        en = 1'b1;
        tick(); tick();
        check(g == on_p(1'b0), "R10 off time not resumed", int'(g), int'(on_p(1'b0)));
        repeat (10) tick();

        // R9 summary of the dead-time monitor
        check(dt_viol == 0, "R9 overlap or short dead time", dt_viol, 0);
        check(dt_rises > 0, "R9 gate turn-ons observed", dt_rises, 1);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(CLK_PERIOD * 100000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule